// File: doc/BRIEF.md
# Call Stack Record Tracker

This block watches a processor's call and stack activity and keeps a running record of it in a 32-bit shift register, for use by a debugger. Every cycle it may receive one-cycle strobes for a subroutine call, a return, a data push, a data pop, a stack-pointer increment and a stack-pointer decrement. Events that add to the stack shift new bits in at the least significant end. Events that remove from the stack shift bits out at the same end, and zeros fill in at the most significant end. A depth counter follows how many valid record bits the register holds, from 0 to 32.

When more bits are added than the register can hold, the oldest bits fall off the top and a sticky overflow flag is raised. When more bits are removed than are present, the depth stops at zero and a sticky underflow flag is raised. The processor never has to stop for this. A debugger reads the register, the depth and both flags on plain output ports, and pulses a clear input to restart the record.

The depth logic is built as a small occupancy state machine with three states. EMPTY means depth is 0, PARTIAL means depth is from 1 to 31, and FULL means depth is 32. The state moves EMPTY to PARTIAL on any add, PARTIAL to FULL when an add reaches 32, FULL to PARTIAL on any remove, and PARTIAL to EMPTY when a remove reaches or passes 0. Clear or reset returns it to EMPTY. An add taken in FULL is an overflow and leaves the state in FULL. A remove taken in EMPTY is an underflow and leaves the state in EMPTY.

Top module: `cstk_record_tracker`

## Requirements
- R1: After reset, the record is 0x00000000, the depth is 0, and both flags are 0.
- R2: A call event shifts the record left by two and puts the pair 2'b11 into bits [1:0]. It adds 2 to the depth.
- R3: A push event or a stack-pointer increment shifts the record left by one and puts a 0 into bit 0. It adds 1 to the depth.
- R4: A pop event or a stack-pointer decrement shifts the record right by one and puts a 0 into bit 31. It subtracts 1 from the depth.
- R5: A return event shifts the record right by two and puts zeros into bits [31:30]. It subtracts 2 from the depth.
- R6: When several strobes are high in the same cycle, only one of them acts. Call wins first, then return, then push or increment, then pop or decrement.
- R7: An add that would take the depth above 32 sets the overflow flag, holds the depth at 32 and drops the oldest bits. Reaching exactly 32 does not set the flag.
- R8: A remove that would take the depth below 0 sets the underflow flag and leaves the depth at 0.
- R9: Both flags are sticky. Only the clear input or reset can clear them, and later events leave them set.
- R10: The clear input zeros the record, the depth and both flags in one cycle. Any event strobed in that same cycle is ignored.
- R11: All results appear on the outputs one clock after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| call_stb | input | 1 | Subroutine call event |
| ret_stb | input | 1 | Return event |
| push_stb | input | 1 | Data push event |
| pop_stb | input | 1 | Data pop event |
| sp_inc_stb | input | 1 | Stack-pointer increment event |
| sp_dec_stb | input | 1 | Stack-pointer decrement event |
| dbg_clr | input | 1 | Debug clear strobe |
| rec_bits | output | 32 | Record shift register contents |
| rec_depth | output | 6 | Number of valid record bits, 0 to 32 |
| ovf_flag | output | 1 | Sticky overflow flag |
| unf_flag | output | 1 | Sticky underflow flag |

## Verification
Two things can happen in the same cycle. The first is two or more event strobes competing. The second is a debug clear arriving together with an event. The vector table raises combinations such as call with return and push, return with pop, increment with decrement, and push with pop. Each result is judged from the record and depth values expected for the winning event alone. In a directed test, clear is pulsed together with a call while the record is full and the overflow flag is set. The check passes only if every output reads zero one cycle later.

// File: rtl/cstk_pkg.sv
package cstk_pkg;

    // Selected stack operation after priority resolution
    typedef enum logic [2:0] {
        OP_NONE,
        OP_CALL,
        OP_RET,
        OP_ADD1,
        OP_SUB1
    } op_e;

    // Occupancy state of the record register
    typedef enum logic [1:0] {
        OCC_EMPTY,
        OCC_PARTIAL,
        OCC_FULL
    } occ_e;

endpackage

// File: rtl/cstk_event_arb.sv
module cstk_event_arb
    import cstk_pkg::*;
(
    input  logic call_i,
    input  logic ret_i,
    input  logic push_i,
    input  logic pop_i,
    input  logic inc_i,
    input  logic dec_i,
    output op_e  op_o
);

    // R6: fixed priority call > return > add one > remove one
    always_comb begin
        if (call_i)               op_o = OP_CALL;
        else if (ret_i)           op_o = OP_RET;
        else if (push_i || inc_i) op_o = OP_ADD1;
        else if (pop_i || dec_i)  op_o = OP_SUB1;
        else                      op_o = OP_NONE;
    end

endmodule

// File: rtl/cstk_shift_reg.sv
module cstk_shift_reg
    import cstk_pkg::*;
#(
    parameter int         REC_W    = 32,
    parameter logic [1:0] CALL_PAT = 2'b11,
    parameter logic       PUSH_BIT = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  op_e              op_i,
    output logic [REC_W-1:0] bits_o
);

    logic [REC_W-1:0] bits_q, bits_d;

    always_comb begin
        bits_d = bits_q;
        unique case (op_i)
            OP_CALL: bits_d = {bits_q[REC_W-3:0], CALL_PAT};
            OP_RET:  bits_d = {2'b00, bits_q[REC_W-1:2]};
            OP_ADD1: bits_d = {bits_q[REC_W-2:0], PUSH_BIT};
            OP_SUB1: bits_d = {1'b0, bits_q[REC_W-1:1]};
            OP_NONE: bits_d = bits_q;
            default: bits_d = bits_q;
        endcase
        if (clr_i) bits_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bits_q <= '0;
        else        bits_q <= bits_d;
    end

    assign bits_o = bits_q;

    // R2: a call leaves the call pattern in the low two bits
    a_r2_call_pattern: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_CALL && !clr_i) |=> (bits_q[1:0] == CALL_PAT));

    // R4: a single remove zero-fills the top bit
    a_r4_pop_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_SUB1 && !clr_i) |=> (bits_q[REC_W-1] == 1'b0));

    // R10: clear empties the register
    a_r10_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (bits_q == '0));

endmodule

// File: rtl/cstk_depth_fsm.sv
module cstk_depth_fsm
    import cstk_pkg::*;
#(
    parameter int REC_W   = 32,
    parameter int DEPTH_W = $clog2(REC_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_i,
    input  op_e                op_i,
    output logic [DEPTH_W-1:0] depth_o,
    output logic               ovf_o,
    output logic               unf_o
);

    localparam logic [DEPTH_W:0]   LIMIT_X = (DEPTH_W + 1)'(REC_W);
    localparam logic [DEPTH_W-1:0] LIMIT   = DEPTH_W'(REC_W);

    occ_e               occ_q, occ_d;
    logic [DEPTH_W-1:0] depth_q, depth_d;
    logic               ovf_q, ovf_d, unf_q, unf_d;
    logic [DEPTH_W:0]   amt, sum;
    logic               grow, shrink;

    always_comb begin
        grow   = (op_i == OP_CALL) || (op_i == OP_ADD1);
        shrink = (op_i == OP_RET)  || (op_i == OP_SUB1);
        amt    = ((op_i == OP_CALL) || (op_i == OP_RET)) ? (DEPTH_W + 1)'(2)
                                                         : (DEPTH_W + 1)'(1);
        sum    = {1'b0, depth_q} + amt;
    end

    // Next-state and output computation
    always_comb begin
        depth_d = depth_q;
        ovf_d   = ovf_q;
        unf_d   = unf_q;
        unique case (occ_q)
            OCC_EMPTY: begin
                if (grow) depth_d = sum[DEPTH_W-1:0];
                else if (shrink) unf_d = 1'b1;
            end
            OCC_PARTIAL: begin
                if (grow) begin
                    if (sum > LIMIT_X) begin
                        ovf_d   = 1'b1;
                        depth_d = LIMIT;
                    end else begin
                        depth_d = sum[DEPTH_W-1:0];
                    end
                end else if (shrink) begin
                    if ({1'b0, depth_q} < amt) begin
                        unf_d   = 1'b1;
                        depth_d = '0;
                    end else begin
                        depth_d = depth_q - amt[DEPTH_W-1:0];
                    end
                end
            end
            OCC_FULL: begin
                if (grow) ovf_d = 1'b1;
                else if (shrink) depth_d = depth_q - amt[DEPTH_W-1:0];
            end
            default: depth_d = depth_q;
        endcase
        if (clr_i) begin
            depth_d = '0;
            ovf_d   = 1'b0;
            unf_d   = 1'b0;
        end
        if (depth_d == '0)        occ_d = OCC_EMPTY;
        else if (depth_d == LIMIT) occ_d = OCC_FULL;
        else                      occ_d = OCC_PARTIAL;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            occ_q   <= OCC_EMPTY;
            depth_q <= '0;
            ovf_q   <= 1'b0;
            unf_q   <= 1'b0;
        end else begin
            occ_q   <= occ_d;
            depth_q <= depth_d;
            ovf_q   <= ovf_d;
            unf_q   <= unf_d;
        end
    end

    assign depth_o = depth_q;
    assign ovf_o   = ovf_q;
    assign unf_o   = unf_q;

    // R7: depth never passes the register width
    a_r7_depth_cap: assert property (@(posedge clk) disable iff (!rst_n)
        depth_q <= LIMIT);

    // R2: a call below the cap adds two
    a_r2_call_depth: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_CALL && !clr_i && depth_q <= LIMIT - DEPTH_W'(2))
        |=> (depth_q == DEPTH_W'($past(depth_q) + DEPTH_W'(2))));

    // R8: removing from an empty record flags underflow and stays at zero
    a_r8_unf_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (shrink && !clr_i && depth_q == '0) |=> (unf_q && depth_q == '0));

    // R9: flags stay set until cleared
    a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !clr_i) |=> ovf_q);
    a_r9_unf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (unf_q && !clr_i) |=> unf_q);

    // R10: clear drops the flags and the depth
    a_r10_clear_state: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (!ovf_q && !unf_q && depth_q == '0 && occ_q == OCC_EMPTY));

endmodule

// File: rtl/cstk_record_tracker.sv
module cstk_record_tracker
    import cstk_pkg::*;
#(
    parameter int REC_W   = 32,
    parameter int DEPTH_W = $clog2(REC_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               call_stb,
    input  logic               ret_stb,
    input  logic               push_stb,
    input  logic               pop_stb,
    input  logic               sp_inc_stb,
    input  logic               sp_dec_stb,
    input  logic               dbg_clr,
    output logic [REC_W-1:0]   rec_bits,
    output logic [DEPTH_W-1:0] rec_depth,
    output logic               ovf_flag,
    output logic               unf_flag
);

    op_e op;

    cstk_event_arb u_arb (
        .call_i (call_stb),
        .ret_i  (ret_stb),
        .push_i (push_stb),
        .pop_i  (pop_stb),
        .inc_i  (sp_inc_stb),
        .dec_i  (sp_dec_stb),
        .op_o   (op)
    );

    cstk_shift_reg #(
        .REC_W    (REC_W),
        .CALL_PAT (2'b11),
        .PUSH_BIT (1'b0)
    ) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (dbg_clr),
        .op_i   (op),
        .bits_o (rec_bits)
    );

    cstk_depth_fsm #(
        .REC_W   (REC_W),
        .DEPTH_W (DEPTH_W)
    ) u_depth (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (dbg_clr),
        .op_i    (op),
        .depth_o (rec_depth),
        .ovf_o   (ovf_flag),
        .unf_o   (unf_flag)
    );

    // R6: a call beats every other strobe for the low pair
    a_r6_call_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (call_stb && !dbg_clr) |=> (rec_bits[1:0] == 2'b11));

endmodule

// File: tb/cstk_record_tracker_tb.sv
module cstk_record_tracker_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        call_stb = 0, ret_stb = 0, push_stb = 0, pop_stb = 0;
    logic        sp_inc_stb = 0, sp_dec_stb = 0, dbg_clr = 0;
    logic [31:0] rec_bits;
    logic [5:0]  rec_depth;
    logic        ovf_flag, unf_flag;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    cstk_record_tracker dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .call_stb   (call_stb),
        .ret_stb    (ret_stb),
        .push_stb   (push_stb),
        .pop_stb    (pop_stb),
        .sp_inc_stb (sp_inc_stb),
        .sp_dec_stb (sp_dec_stb),
        .dbg_clr    (dbg_clr),
        .rec_bits   (rec_bits),
        .rec_depth  (rec_depth),
        .ovf_flag   (ovf_flag),
        .unf_flag   (unf_flag)
    );

    // Vector: {ev[5:0] = call,ret,push,pop,inc,dec ; clr ; depth ; ovf ; unf ; bits}
    localparam int NV = 14;
    localparam logic [46:0] VECS [NV] = '{
        {6'b001000, 1'b0, 6'd1, 1'b0, 1'b0, 32'h0000_0000}, // R3 push
        {6'b100000, 1'b0, 6'd3, 1'b0, 1'b0, 32'h0000_0003}, // R2 call
        {6'b100000, 1'b0, 6'd5, 1'b0, 1'b0, 32'h0000_000F}, // R2 call
        {6'b000100, 1'b0, 6'd4, 1'b0, 1'b0, 32'h0000_0007}, // R4 pop
        {6'b010000, 1'b0, 6'd2, 1'b0, 1'b0, 32'h0000_0001}, // R5 return
        {6'b111000, 1'b0, 6'd4, 1'b0, 1'b0, 32'h0000_0007}, // R6 call wins
        {6'b010100, 1'b0, 6'd2, 1'b0, 1'b0, 32'h0000_0001}, // R6 return wins
        {6'b000011, 1'b0, 6'd3, 1'b0, 1'b0, 32'h0000_0002}, // R6 inc wins
        {6'b000001, 1'b0, 6'd2, 1'b0, 1'b0, 32'h0000_0001}, // R4 dec
        {6'b001100, 1'b0, 6'd3, 1'b0, 1'b0, 32'h0000_0002}, // R6 push wins
        {6'b010000, 1'b0, 6'd1, 1'b0, 1'b0, 32'h0000_0000}, // R5 return
        {6'b010000, 1'b0, 6'd0, 1'b0, 1'b1, 32'h0000_0000}, // R8 underflow
        {6'b000000, 1'b0, 6'd0, 1'b0, 1'b1, 32'h0000_0000}, // R9 sticky
        {6'b000000, 1'b1, 6'd0, 1'b0, 1'b0, 32'h0000_0000}  // R10 clear
    };

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic chk_all(input string req, input logic [31:0] eb, input logic [5:0] ed,
                           input logic eo, input logic eu);
        chk({req, " bits"},  rec_bits, eb);
        chk({req, " depth"}, {26'd0, rec_depth}, {26'd0, ed});
        chk({req, " ovf"},   {31'd0, ovf_flag}, {31'd0, eo});
        chk({req, " unf"},   {31'd0, unf_flag}, {31'd0, eu});
    endtask

    // Drive at a falling edge, result visible at the next falling edge (R11)
    task automatic step(input logic [5:0] ev, input logic clr);
        {call_stb, ret_stb, push_stb, pop_stb, sp_inc_stb, sp_dec_stb} = ev;
        dbg_clr = clr;
        @(negedge clk);
        {call_stb, ret_stb, push_stb, pop_stb, sp_inc_stb, sp_dec_stb} = '0;
        dbg_clr = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk_all("R1 reset", 32'h0, 6'd0, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            step(VECS[i][46:41], VECS[i][40]);
            chk_all($sformatf("R11 vec%0d", i), VECS[i][31:0], VECS[i][39:34],
                    VECS[i][33], VECS[i][32]);
        end

        // R7: sixteen calls fill exactly to 32 without overflow
        for (int i = 0; i < 16; i++) step(6'b100000, 1'b0);
        chk_all("R7 exact fill", 32'hFFFF_FFFF, 6'd32, 1'b0, 1'b0);

        // R7: one more push overflows, oldest bit lost
        step(6'b001000, 1'b0);
        chk_all("R7 overflow", 32'hFFFF_FFFE, 6'd32, 1'b1, 1'b0);

        // R9: a later pop keeps overflow set
        step(6'b000100, 1'b0);
        chk_all("R9 ovf sticky", 32'h7FFF_FFFF, 6'd31, 1'b1, 1'b0);

        // R7: call at depth 31 overflows
        step(6'b100000, 1'b0);
        chk_all("R7 call overflow", 32'hFFFF_FFFF, 6'd32, 1'b1, 1'b0);

        // R10: clear with a simultaneous call, call ignored
        step(6'b100000, 1'b1);
        chk_all("R10 clear beats call", 32'h0, 6'd0, 1'b0, 1'b0);

        // R8: decrement from empty
        step(6'b000001, 1'b0);
        chk_all("R8 dec empty", 32'h0, 6'd0, 1'b0, 1'b1);

        // R3: increment after underflow keeps flag and grows
        step(6'b000010, 1'b0);
        chk_all("R3 inc", 32'h0, 6'd1, 1'b0, 1'b1);

        // R1: reset mid-run
        step(6'b100000, 1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        chk_all("R1 mid reset", 32'h0, 6'd0, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        finish_run();
    end

endmodule